// File: doc/BRIEF.md
# Amplifier Operating-State and Configuration Controller

This block decides whether a pulse-density-modulated speaker amplifier is powered down, idling with its driver off, or driving the speaker. It also holds the amplifier settings: output slew rate, two performance-mode fields, a 32 kHz rate flag, the high-pass filter enable, and the supply profile used at start-up. An upstream detector recognises control codes that travel as silent audio words. For each code word it gives one strobe together with a small code number. It also reports when audio words arrive, when a run-length error occurs, and whether the bit clock is present.

The controller counts runs of identical code words itself. An action fires on the exact strobe that brings a run to its threshold. Settings can only be changed while the amplifier idles with its driver off. Some settings are flipped or stepped rather than written. A one-shot page-select code switches how the next run is interpreted. Every setting returns to its default only when the bit clock disappears.

Top module: `ampStateCtrl`

## Requirements
- R1: While `rst_n` is low or `clkPresent` is low, the state is OFF. From OFF, the first clock edge that samples `clkPresent` high moves the state to STANDBY. Code strobes, audio strobes and run errors have no effect while the state is OFF.
- R2: A clock edge that samples `clkPresent` low forces OFF from any state and restores every setting to its default: `slewSel`=00, `pc1Sel`=0, `pc2Sel`=00, `rate32k`=0, `hpfEn`=1, `prof5v`=0.
- R3: `stateOut` encodes OFF=0, STANDBY=1 and ON=2. `drvEn` is high exactly when the state is ON.
- R4: A run is a sequence of code strobes that all carry the same `codeId`. A run survives idle cycles. It ends when a strobe carries a different `codeId` or when `audioStb` is seen. `audioStb` takes priority over a code strobe in the same cycle. A code action takes effect at the clock edge that samples the strobe completing its count.
- R5: In STANDBY, a run reaching the count given here moves the state to ON: code 1 at 4 strobes (sets `prof5v`=0), code 9 at 32 strobes (sets `prof5v`=0), or code 10 at 32 strobes (sets `prof5v`=1).
- R6: In STANDBY, `audioStb` moves the state to ON and leaves `prof5v` at its last value. After a clock loss that value is 0.
- R7: In ON, any of these moves the state to STANDBY: a run of code 2 reaching 32 strobes, a run of any code reaching 64 strobes, or a `runErr` pulse.
- R8: One run causes at most one state transition. This holds however long the run continues.
- R9: In STANDBY, runs of 32 strobes change settings as follows: code 4 sets `rate32k`, code 5 clears `hpfEn`, and code 3 inverts `slewSel[1]`.
- R10: In STANDBY, a run of code 6 reaching 32 strobes selects the second code page for the next run only. On that page, 32 strobes of code 9 invert `slewSel[0]` without starting up, code 3 inverts `pc1Sel`, code 10 increments `pc2Sel` (11 wraps to 00), and other codes do nothing. Later runs use the first page again.
- R11: Setting codes received in ON leave every setting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkPresent | input | 1 | High while the audio bit clock is detected |
| codeStb | input | 1 | One-cycle strobe per received control-code word |
| codeId | input | 4 | Number of the received code (1 to 10) |
| audioStb | input | 1 | One-cycle strobe per received audio word |
| runErr | input | 1 | One-cycle pulse on a run-length error |
| stateOut | output | 2 | Operating state: 0 OFF, 1 STANDBY, 2 ON |
| drvEn | output | 1 | Output driver enable |
| slewSel | output | 2 | Slew select: 00 5 ns, 01 10 ns, 10 20 ns, 11 40 ns |
| pc1Sel | output | 1 | Performance mode bit, 0 favours SNR |
| pc2Sel | output | 2 | Performance mode step field |
| rate32k | output | 1 | 32 kHz sample-rate mode |
| hpfEn | output | 1 | Input high-pass filter enable |
| prof5v | output | 1 | Start-up supply profile, 1 for 5.0 V |

## Verification
Code runs are sent in several forms. A run stopping one strobe short of its threshold and then finished shows that counts survive idle gaps and fire on the exact strobe. Runs split by a different code or by an audio word show that a run really resets. Runs carried far past 32 and 64 strobes show that one run never causes a second transition.

The same code numbers are sent both with and without a preceding page-select run. This separates the two pages and shows the select is consumed after one run. The stepping field is driven through a full wrap. Setting codes sent while ON, and a clock loss followed by audio-only start-up, separate honoured events from ignored ones and the kept profile from the default.

// File: rtl/ampStatePkg.sv
package ampStatePkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_STBY = 2'd1,
    ST_ON   = 2'd2
  } ampState_e;

  // strobes from the control side to the settings registers
  typedef struct packed {
    logic clear;     // clock lost: restore defaults
    logic set32k;
    logic clrHpf;
    logic flipSr1;
    logic flipSr0;
    logic flipPc1;
    logic incPc2;
    logic setProf36;
    logic setProf50;
  } cfgStrb_t;

  // code numbers understood by the controller
  localparam int CODE_FAST   = 1;
  localparam int CODE_STBY   = 2;
  localparam int CODE_SR_HI  = 3;   // page 2: performance bit
  localparam int CODE_RATE   = 4;
  localparam int CODE_HPF    = 5;
  localparam int CODE_PAGE   = 6;
  localparam int CODE_UP36   = 9;   // page 2: slew low bit
  localparam int CODE_UP50   = 10;  // page 2: performance step

endpackage

// File: rtl/ampCtrlFsm.sv
module ampCtrlFsm
  import ampStatePkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int FAST_REPS = 4,
  parameter int CFG_REPS  = 32,
  parameter int ANY_REPS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkPresent,
  input  logic              codeStb,
  input  logic [CODE_W-1:0] codeId,
  input  logic              audioStb,
  input  logic              runErr,
  output ampState_e         state,
  output cfgStrb_t          strb
);

  // counter saturates one above the largest threshold so each threshold is met once per run
  localparam int SAT_VAL = ANY_REPS + 1;
  localparam int CNT_W   = $clog2(SAT_VAL + 1);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(SAT_VAL);
  localparam logic [CNT_W-1:0] FAST_CNT = CNT_W'(FAST_REPS);
  localparam logic [CNT_W-1:0] CFG_CNT  = CNT_W'(CFG_REPS);
  localparam logic [CNT_W-1:0] ANY_CNT  = CNT_W'(ANY_REPS);

  logic [CNT_W-1:0]  runCnt;
  logic [CODE_W-1:0] runId;
  logic              runLive;
  logic              runPage2;
  logic              runUsed;
  logic              page2Armed;

  logic              codeIn;
  logic              newRun;
  logic [CNT_W-1:0]  nextCnt;
  logic              effPage2;
  logic              effUsed;
  logic              hitFast, hitCfg, hitAny;
  logic              p1Hit, p2Hit;
  logic              goOnCode, goOnAudio, goSbCode, goSbErr;
  logic              armEv;
  logic              inStby, inOn;

  function automatic logic isCode(input logic [CODE_W-1:0] id, input int num);
    return id == CODE_W'(num);
  endfunction

  assign inStby = (state == ST_STBY);
  assign inOn   = (state == ST_ON);
  assign codeIn = codeStb && !audioStb;
  assign newRun = !runLive || (codeId != runId);

  always_comb begin
    if (newRun)               nextCnt = CNT_W'(1);
    else if (runCnt == SAT_CNT) nextCnt = SAT_CNT;
    else                      nextCnt = runCnt + CNT_W'(1);
  end

  assign effPage2 = newRun ? page2Armed : runPage2;
  assign effUsed  = newRun ? 1'b0 : runUsed;

  assign hitFast = codeIn && (nextCnt == FAST_CNT);
  assign hitCfg  = codeIn && (nextCnt == CFG_CNT);
  assign hitAny  = codeIn && (nextCnt == ANY_CNT);

  // threshold hits qualified by page, only meaningful in STANDBY
  assign p1Hit = clkPresent && inStby && !effPage2;
  assign p2Hit = clkPresent && inStby &&  effPage2;

  assign goOnAudio = clkPresent && inStby && audioStb;
  assign goOnCode  = p1Hit && !effUsed &&
                     ((hitFast && isCode(codeId, CODE_FAST)) ||
                      (hitCfg && (isCode(codeId, CODE_UP36) || isCode(codeId, CODE_UP50))));
  assign goSbErr   = clkPresent && inOn && runErr;
  assign goSbCode  = clkPresent && inOn && !effUsed &&
                     ((hitCfg && !effPage2 && isCode(codeId, CODE_STBY)) || hitAny);
  assign armEv     = p1Hit && hitCfg && isCode(codeId, CODE_PAGE);

  always_comb begin
    strb           = '0;
    strb.clear     = !clkPresent;
    strb.set32k    = p1Hit && hitCfg && isCode(codeId, CODE_RATE);
    strb.clrHpf    = p1Hit && hitCfg && isCode(codeId, CODE_HPF);
    strb.flipSr1   = p1Hit && hitCfg && isCode(codeId, CODE_SR_HI);
    strb.flipSr0   = p2Hit && hitCfg && isCode(codeId, CODE_UP36);
    strb.flipPc1   = p2Hit && hitCfg && isCode(codeId, CODE_SR_HI);
    strb.incPc2    = p2Hit && hitCfg && isCode(codeId, CODE_UP50);
    strb.setProf36 = goOnCode && !isCode(codeId, CODE_UP50);
    strb.setProf50 = goOnCode &&  isCode(codeId, CODE_UP50);
  end

  // operating state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
    end else if (!clkPresent) begin
      state <= ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  state <= ST_STBY;
        ST_STBY: if (goOnAudio || goOnCode) state <= ST_ON;
        ST_ON:   if (goSbErr || goSbCode)   state <= ST_STBY;
        default: state <= ST_OFF;
      endcase
    end
  end

  // run tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt   <= '0;
      runId    <= '0;
      runLive  <= 1'b0;
      runPage2 <= 1'b0;
      runUsed  <= 1'b0;
    end else if (!clkPresent || state == ST_OFF || audioStb) begin
      runCnt   <= '0;
      runLive  <= 1'b0;
      runPage2 <= 1'b0;
      runUsed  <= 1'b0;
    end else if (codeIn) begin
      runCnt   <= nextCnt;
      runId    <= codeId;
      runLive  <= 1'b1;
      runPage2 <= effPage2;
      runUsed  <= effUsed || goOnCode || goSbCode;
    end
  end

  // page select: armed by one run, consumed when the next run starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page2Armed <= 1'b0;
    end else if (!clkPresent || !inStby || goOnAudio || goOnCode) begin
      page2Armed <= 1'b0;
    end else if (armEv) begin
      page2Armed <= 1'b1;
    end else if (codeIn && newRun) begin
      page2Armed <= 1'b0;
    end
  end

endmodule

// File: rtl/ampCfgRegs.sv
module ampCfgRegs
  import ampStatePkg::*;
#(
  parameter int SR_W  = 2,
  parameter int PC2_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfgStrb_t         strb,
  output logic [SR_W-1:0]  slewSel,
  output logic             pc1Sel,
  output logic [PC2_W-1:0] pc2Sel,
  output logic             rate32k,
  output logic             hpfEn,
  output logic             prof5v
);

  localparam int SR_HI = SR_W - 1;

  // slew bits: each bit has its own inversion strobe
  genvar gi;
  generate
    for (gi = 0; gi < SR_W; gi++) begin : g_sr
      logic flip;
      if (gi == SR_HI) begin : g_hi
        assign flip = strb.flipSr1;
      end else if (gi == 0) begin : g_lo
        assign flip = strb.flipSr0;
      end else begin : g_mid
        assign flip = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          slewSel[gi] <= 1'b0;
        else if (strb.clear) slewSel[gi] <= 1'b0;
        else if (flip)       slewSel[gi] <= ~slewSel[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc1Sel  <= 1'b0;
      pc2Sel  <= '0;
      rate32k <= 1'b0;
      hpfEn   <= 1'b1;
      prof5v  <= 1'b0;
    end else if (strb.clear) begin
      pc1Sel  <= 1'b0;
      pc2Sel  <= '0;
      rate32k <= 1'b0;
      hpfEn   <= 1'b1;
      prof5v  <= 1'b0;
    end else begin
      if (strb.flipPc1)   pc1Sel  <= ~pc1Sel;
      if (strb.incPc2)    pc2Sel  <= pc2Sel + PC2_W'(1);
      if (strb.set32k)    rate32k <= 1'b1;
      if (strb.clrHpf)    hpfEn   <= 1'b0;
      if (strb.setProf50) prof5v  <= 1'b1;
      else if (strb.setProf36) prof5v <= 1'b0;
    end
  end

endmodule

// File: rtl/ampStateCtrl.sv
module ampStateCtrl
  import ampStatePkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int FAST_REPS = 4,
  parameter int CFG_REPS  = 32,
  parameter int ANY_REPS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkPresent,
  input  logic              codeStb,
  input  logic [CODE_W-1:0] codeId,
  input  logic              audioStb,
  input  logic              runErr,
  output logic [1:0]        stateOut,
  output logic              drvEn,
  output logic [1:0]        slewSel,
  output logic              pc1Sel,
  output logic [1:0]        pc2Sel,
  output logic              rate32k,
  output logic              hpfEn,
  output logic              prof5v
);

  ampState_e state;
  cfgStrb_t  strb;

  ampCtrlFsm #(
    .CODE_W   (CODE_W),
    .FAST_REPS(FAST_REPS),
    .CFG_REPS (CFG_REPS),
    .ANY_REPS (ANY_REPS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clkPresent(clkPresent),
    .codeStb   (codeStb),
    .codeId    (codeId),
    .audioStb  (audioStb),
    .runErr    (runErr),
    .state     (state),
    .strb      (strb)
  );

  ampCfgRegs #(
    .SR_W (2),
    .PC2_W(2)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .slewSel(slewSel),
    .pc1Sel (pc1Sel),
    .pc2Sel (pc2Sel),
    .rate32k(rate32k),
    .hpfEn  (hpfEn),
    .prof5v (prof5v)
  );

  assign stateOut = state;
  assign drvEn    = (state == ST_ON);

endmodule

// File: rtl/ampStateCtrl_chk.sv
module ampStateCtrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clkPresent,
  input logic       runErr,
  input logic [1:0] stateOut,
  input logic       drvEn,
  input logic [1:0] slewSel,
  input logic       pc1Sel,
  input logic [1:0] pc2Sel,
  input logic       rate32k,
  input logic       hpfEn,
  input logic       prof5v
);

  assert_off_to_stby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 2'd0 && clkPresent) |=> stateOut == 2'd1);

  assert_clock_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clkPresent |=> (stateOut == 2'd0 && slewSel == 2'b00 && !pc1Sel &&
                     pc2Sel == 2'b00 && !rate32k && hpfEn && !prof5v));

  assert_drv_needs_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drvEn |-> $past(clkPresent));

  assert_run_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 2'd2 && clkPresent && runErr) |=> stateOut == 2'd1);

  assert_rate_only_in_stby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate32k) |-> $past(stateOut) == 2'd1);

  assert_pc2_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clkPresent) && !$stable(pc2Sel)) |-> pc2Sel == $past(pc2Sel) + 2'd1);

  assert_cfg_frozen_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stateOut == 2'd2 && clkPresent) |=>
      ($stable(slewSel) && $stable(pc1Sel) && $stable(pc2Sel) &&
       $stable(rate32k) && $stable(hpfEn)));

endmodule

bind ampStateCtrl ampStateCtrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clkPresent(clkPresent),
  .runErr    (runErr),
  .stateOut  (stateOut),
  .drvEn     (drvEn),
  .slewSel   (slewSel),
  .pc1Sel    (pc1Sel),
  .pc2Sel    (pc2Sel),
  .rate32k   (rate32k),
  .hpfEn     (hpfEn),
  .prof5v    (prof5v)
);

// File: tb/tb_ampStateCtrl.sv
`timescale 1ns/1ps
module tb_ampStateCtrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clkPresent = 1'b0;
  logic       codeStb = 1'b0;
  logic [3:0] codeId = '0;
  logic       audioStb = 1'b0;
  logic       runErr = 1'b0;
  logic [1:0] stateOut;
  logic       drvEn;
  logic [1:0] slewSel;
  logic       pc1Sel;
  logic [1:0] pc2Sel;
  logic       rate32k;
  logic       hpfEn;
  logic       prof5v;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  ampStateCtrl dut (
    .clk(clk), .rst_n(rst_n), .clkPresent(clkPresent), .codeStb(codeStb),
    .codeId(codeId), .audioStb(audioStb), .runErr(runErr), .stateOut(stateOut),
    .drvEn(drvEn), .slewSel(slewSel), .pc1Sel(pc1Sel), .pc2Sel(pc2Sel),
    .rate32k(rate32k), .hpfEn(hpfEn), .prof5v(prof5v)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // back-to-back strobes; returns at the negedge after the last one was sampled
  task automatic sendCode(input int id, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      codeStb = 1'b1;
      codeId  = 4'(id);
    end
    @(negedge clk);
    codeStb = 1'b0;
  endtask

  task automatic pulseAudio();
    @(negedge clk); audioStb = 1'b1;
    @(negedge clk); audioStb = 1'b0;
  endtask

  task automatic pulseErr();
    @(negedge clk); runErr = 1'b1;
    @(negedge clk); runErr = 1'b0;
  endtask

  task automatic checkDefaults(input string tag);
    chk({tag, " slew"}, slewSel, 0);
    chk({tag, " pc1"}, pc1Sel, 0);
    chk({tag, " pc2"}, pc2Sel, 0);
    chk({tag, " rate"}, rate32k, 0);
    chk({tag, " hpf"}, hpfEn, 1);
    chk({tag, " prof"}, prof5v, 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", stateOut, 0);
    chk("R3 reset drvEn", drvEn, 0);
    checkDefaults("R2 reset");
    sendCode(1, 4);
    pulseAudio();
    chk("R1 codes ignored in OFF", stateOut, 0);
    @(negedge clk); clkPresent = 1'b1;
    @(negedge clk);
    chk("R1 clock up to STANDBY", stateOut, 1);
  endtask

  task automatic testFastStart();
    sendCode(1, 3);
    chk("R4 fast start short by one", stateOut, 1);
    sendCode(1, 1);
    chk("R5 fast start state", stateOut, 2);
    chk("R3 drvEn in ON", drvEn, 1);
    chk("R5 fast start profile", prof5v, 0);
  endtask

  task automatic testOnRules();
    sendCode(4, 32);
    chk("R11 rate code in ON ignored", rate32k, 0);
    chk("R11 state kept", stateOut, 2);
    sendCode(4, 32);
    chk("R7 any code x64", stateOut, 1);
    chk("R3 drvEn in STANDBY", drvEn, 0);
    sendCode(4, 40);
    chk("R8 long run no refire state", stateOut, 1);
    chk("R8 long run no config", rate32k, 0);
    sendCode(9, 32);
    chk("R5 code 9 start", stateOut, 2);
    sendCode(9, 32);
    chk("R8 code 9 run to 64 stays ON", stateOut, 2);
    pulseErr();
    chk("R7 run error", stateOut, 1);
  endtask

  task automatic testPage1Cfg();
    sendCode(4, 32);
    chk("R9 rate32k set", rate32k, 1);
    sendCode(5, 32);
    chk("R9 hpf cleared", hpfEn, 0);
    sendCode(3, 32);
    chk("R9 slew high bit", slewSel, 2);
  endtask

  task automatic testPage2Cfg();
    sendCode(6, 32);
    sendCode(9, 32);
    chk("R10 slew low bit", slewSel, 3);
    chk("R10 page 2 code 9 no start", stateOut, 1);
    for (int k = 1; k <= 4; k++) begin
      sendCode(6, 32);
      sendCode(10, 32);
      chk("R10 pc2 step", pc2Sel, k % 4);
    end
    sendCode(6, 32);
    sendCode(3, 32);
    chk("R10 pc1 flip", pc1Sel, 1);
    chk("R10 slew untouched by page 2 code 3", slewSel, 3);
    sendCode(7, 1);
    sendCode(3, 32);
    chk("R10 page 1 again slew", slewSel, 1);
    chk("R10 page 1 again pc1", pc1Sel, 1);
    chk("R10 still STANDBY", stateOut, 1);
  endtask

  task automatic testProfileAndAudio();
    sendCode(10, 32);
    chk("R5 code 10 start", stateOut, 2);
    chk("R5 code 10 profile", prof5v, 1);
    sendCode(2, 20);
    pulseAudio();
    sendCode(2, 12);
    chk("R4 audio breaks run", stateOut, 2);
    sendCode(2, 32);
    chk("R7 standby code", stateOut, 1);
    chk("R11 settings kept slew", slewSel, 1);
    chk("R11 settings kept rate", rate32k, 1);
    pulseAudio();
    chk("R6 audio start", stateOut, 2);
    chk("R6 profile reused", prof5v, 1);
  endtask

  task automatic testClockLoss();
    @(negedge clk); clkPresent = 1'b0;
    @(negedge clk);
    chk("R2 clock loss state", stateOut, 0);
    checkDefaults("R2 clock loss");
    pulseAudio();
    chk("R1 audio ignored in OFF", stateOut, 0);
    clkPresent = 1'b1;
    @(negedge clk);
    chk("R1 clock back", stateOut, 1);
    sendCode(5, 20);
    sendCode(7, 1);
    sendCode(5, 12);
    chk("R4 other code breaks run", hpfEn, 1);
    pulseAudio();
    chk("R6 audio start after loss", stateOut, 2);
    chk("R6 default profile", prof5v, 0);
  endtask

  initial begin
    testReset();
    testFastStart();
    testOnRules();
    testPage1Cfg();
    testPage2Cfg();
    testProfileAndAudio();
    testClockLoss();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule